// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block watches four external interrupt pins and turns their activity into prioritised interrupt requests for a CPU core. Each pin first goes through a two-flop synchroniser. The fourth pin then also passes through a digital glitch filter whose sample rate can be selected. After that, the block looks for the edge or level condition chosen for each pin. Edge events are latched in a pending flag. Level conditions are presented directly, for as long as they hold.

The two low-numbered pins accept edges in either polarity and levels in either polarity. The two high-numbered pins accept a rising edge, a falling edge, or both edges, but no level modes. The CPU sees a request line and a vector address. It takes the presented request with a one-cycle acknowledge. Independently of the enables, the two high-numbered pins also give one-cycle event pulses that a counter/timer can count.

Configuration is done one pin at a time. A write strobe selects the pin and carries the trigger mode and the enable bit for it.

Top module: `extint_unit`

## Requirements
- R1: Every pin is resynchronised by two flip-flops. If a pin on an enabled rising-edge line changes just before clock edge E1, irqReq is still low after edge E2 and is high after edge E3 (pins 0 to 2).
- R2: On pins 0 and 1, cfgMode selects the trigger as follows: 0 is a rising edge, 1 is a falling edge, 2 is a high level, 3 is a low level.
- R3: On pins 2 and 3, cfgMode selects the trigger as follows: 0 is a rising edge, 1 is a falling edge, and 2 or 3 means both edges. A steady level on these pins never raises a request.
- R4: While irqReq is high, irqVector is 0x03 for pin 0, 0x0B for pin 1, 0x13 for pin 2 and 0x1B for pin 3. While irqReq is low, irqVector is 0x00.
- R5: When several enabled requests are active at the same time, the lowest-numbered pin is presented first.
- R6: irqAck pulsed while irqReq is high clears the pending edge flag of the pin being presented, and only that flag. A level request stays asserted through irqAck for as long as its level lasts.
- R7: A configuration write to a pin clears that pin's pending edge flag in the same clock edge.
- R8: A pin whose enable bit is 0 sets no pending flag and produces no request. The enable bits reset to 0.
- R9: Pin 3 is filtered after its synchroniser. filtSel 0 samples every cycle, 1 samples every 16 cycles, and 2 or 3 samples every 64 cycles. A new level is accepted only when two consecutive samples differ from the current filtered level. Pulses of 2, 32 and 128 cycles are accepted. Pulses of 1, 16 and 64 cycles are rejected.
- R10: tmrEvt[0] and tmrEvt[1] each give a one-cycle pulse for every trigger event of pin 2 and pin 3 respectively, according to that pin's mode and whatever its enable bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 4 | Raw external interrupt pins, bit n is pin n |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Pin addressed by the configuration write |
| cfgMode | input | 2 | Trigger mode written for the selected pin |
| cfgEnable | input | 1 | Enable bit written for the selected pin |
| filtSel | input | 2 | Sample-rate select for the pin 3 filter |
| irqAck | input | 1 | One-cycle acknowledge of the presented request |
| irqReq | output | 1 | An enabled request is active |
| irqVector | output | 8 | Vector address of the presented request |
| tmrEvt | output | 2 | Event pulses from pins 2 and 3 for a timer |

## Verification
The assertions rely on a few things. Configuration arrives only through the write strobe, so a shadow copy of the enables taken from the ports matches the block. Reset is applied before the first write. After a pin is written in an edge mode, the next cycle cannot present that pin's vector, because the write overrides any edge that arrives in the same cycle. The stimulus changes pins only at falling clock edges and holds each level for several cycles, so no result depends on metastability. It also waits for all pins to settle low before each new configuration, so no stale edge crosses from one test into the next.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int PIN_COUNT = 4;
  localparam int SEL_W = $clog2(PIN_COUNT);

  typedef logic [1:0] trigMode_t;

  typedef struct packed {
    logic [PIN_COUNT-1:0] setPend;
    logic [PIN_COUNT-1:0] clrPend;
    logic [1:0]           tmrPulse;
  } extStrobe_t;
endpackage

// File: rtl/extint_dp.sv
module extint_dp
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_MATCH  = 2,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [PIN_COUNT-1:0]                pinIn,
  input  logic                                cfgWrEn,
  input  logic [SEL_W-1:0]                    cfgSel,
  input  logic [1:0]                          cfgMode,
  input  logic                                cfgEnable,
  input  logic [1:0]                          filtSel,
  input  extStrobe_t                          strobe,
  output logic [PIN_COUNT-1:0]                condLvl,
  output logic [PIN_COUNT-1:0]                riseEvt,
  output logic [PIN_COUNT-1:0]                fallEvt,
  output logic [PIN_COUNT-1:0][1:0]           modeQ,
  output logic [PIN_COUNT-1:0]                enQ,
  output logic [PIN_COUNT-1:0]                pendQ,
  output logic [1:0]                          tmrEvt
);
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam int MID_W = $clog2(DIV_MID);
  localparam int MW    = $clog2(FILT_MATCH + 1);
  localparam logic [MW-1:0] MATCH_LAST = MW'(FILT_MATCH - 1);

  logic [PIN_COUNT-1:0][SYNC_STAGES-1:0] syncChain;
  logic [PIN_COUNT-1:0] syncLvl;
  logic [PIN_COUNT-1:0] prevLvl;
  logic [PRE_W-1:0]     preCnt;
  logic [MW-1:0]        matchCnt;
  logic                 filtLvl;
  logic                 sampleTick;

  // Synchroniser chains, one per pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
    end else begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        syncChain[p] <= {syncChain[p][SYNC_STAGES-2:0], pinIn[p]};
      end
    end
  end

  always_comb begin
    for (int p = 0; p < PIN_COUNT; p++) syncLvl[p] = syncChain[p][SYNC_STAGES-1];
  end

  // Free-running prescaler for the filter sample tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    unique case (filtSel)
      2'd0:    sampleTick = 1'b1;
      2'd1:    sampleTick = (preCnt[MID_W-1:0] == '1);
      default: sampleTick = (preCnt == '1);
    endcase
  end

  // Glitch filter on the last pin: the level must differ on consecutive ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLvl  <= 1'b0;
      matchCnt <= '0;
    end else if (sampleTick) begin
      if (syncLvl[PIN_COUNT-1] == filtLvl) begin
        matchCnt <= '0;
      end else if (matchCnt == MATCH_LAST) begin
        filtLvl  <= syncLvl[PIN_COUNT-1];
        matchCnt <= '0;
      end else begin
        matchCnt <= matchCnt + 1'b1;
      end
    end
  end

  assign condLvl = {filtLvl, syncLvl[PIN_COUNT-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= condLvl;
  end

  assign riseEvt = condLvl & ~prevLvl;
  assign fallEvt = ~condLvl & prevLvl;

  // Configuration registers and pending flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      enQ   <= '0;
      pendQ <= '0;
    end else begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        if (cfgWrEn && cfgSel == SEL_W'(p)) begin
          modeQ[p] <= cfgMode;
          enQ[p]   <= cfgEnable;
          pendQ[p] <= 1'b0;
        end else if (strobe.setPend[p]) begin
          pendQ[p] <= 1'b1;
        end else if (strobe.clrPend[p]) begin
          pendQ[p] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmrEvt <= '0;
    else       tmrEvt <= strobe.tmrPulse;
  end
endmodule

// File: rtl/extint_ctl.sv
module extint_ctl
  import extint_pkg::*;
#(
  parameter int         LEVEL_PINS = 2,
  parameter logic [7:0] VEC_BASE   = 8'h03,
  parameter logic [7:0] VEC_STEP   = 8'h08
) (
  input  logic [PIN_COUNT-1:0]      condLvl,
  input  logic [PIN_COUNT-1:0]      riseEvt,
  input  logic [PIN_COUNT-1:0]      fallEvt,
  input  logic [PIN_COUNT-1:0][1:0] modeQ,
  input  logic [PIN_COUNT-1:0]      enQ,
  input  logic [PIN_COUNT-1:0]      pendQ,
  input  logic                      irqAck,
  output extStrobe_t                strobe,
  output logic                      irqReq,
  output logic [7:0]                irqVector
);
  logic [PIN_COUNT-1:0] edgeHit;
  logic [PIN_COUNT-1:0] levelAct;
  logic [PIN_COUNT-1:0] active;
  logic [SEL_W-1:0]     winner;

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
    if (g < LEVEL_PINS) begin : g_lvl
      assign edgeHit[g]  = (modeQ[g] == 2'd0 && riseEvt[g]) ||
                           (modeQ[g] == 2'd1 && fallEvt[g]);
      assign levelAct[g] = (modeQ[g] == 2'd2 &&  condLvl[g]) ||
                           (modeQ[g] == 2'd3 && !condLvl[g]);
    end else begin : g_both
      assign edgeHit[g]  = (modeQ[g] == 2'd0 && riseEvt[g]) ||
                           (modeQ[g] == 2'd1 && fallEvt[g]) ||
                           (modeQ[g][1] && (riseEvt[g] || fallEvt[g]));
      assign levelAct[g] = 1'b0;
    end
    assign active[g] = enQ[g] && (pendQ[g] || levelAct[g]);
  end

  // Fixed priority: lowest pin index wins
  always_comb begin
    winner = '0;
    for (int p = PIN_COUNT - 1; p >= 0; p--) begin
      if (active[p]) winner = SEL_W'(p);
    end
  end

  assign irqReq    = |active;
  assign irqVector = irqReq ? VEC_BASE + VEC_STEP * {{(8-SEL_W){1'b0}}, winner} : 8'h00;

  always_comb begin
    strobe.setPend  = enQ & edgeHit;
    strobe.clrPend  = '0;
    if (irqAck && irqReq) strobe.clrPend[winner] = 1'b1;
    strobe.tmrPulse = edgeHit[PIN_COUNT-1:PIN_COUNT-2];
  end
endmodule

// File: rtl/extint_unit.sv
module extint_unit
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_MATCH  = 2,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] pinIn,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic [1:0] cfgMode,
  input  logic       cfgEnable,
  input  logic [1:0] filtSel,
  input  logic       irqAck,
  output logic       irqReq,
  output logic [7:0] irqVector,
  output logic [1:0] tmrEvt
);
  extStrobe_t                 strobe;
  logic [PIN_COUNT-1:0]       condLvl, riseEvt, fallEvt, enQ, pendQ;
  logic [PIN_COUNT-1:0][1:0]  modeQ;

  extint_dp #(
    .SYNC_STAGES(SYNC_STAGES), .FILT_MATCH(FILT_MATCH),
    .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgMode(cfgMode), .cfgEnable(cfgEnable),
    .filtSel(filtSel), .strobe(strobe),
    .condLvl(condLvl), .riseEvt(riseEvt), .fallEvt(fallEvt),
    .modeQ(modeQ), .enQ(enQ), .pendQ(pendQ), .tmrEvt(tmrEvt)
  );

  extint_ctl u_ctl (
    .condLvl(condLvl), .riseEvt(riseEvt), .fallEvt(fallEvt),
    .modeQ(modeQ), .enQ(enQ), .pendQ(pendQ), .irqAck(irqAck),
    .strobe(strobe), .irqReq(irqReq), .irqVector(irqVector)
  );
endmodule

// File: rtl/extint_unit_chk.sv
module extint_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [1:0] cfgSel,
  input logic [1:0] cfgMode,
  input logic       cfgEnable,
  input logic       irqReq,
  input logic [7:0] irqVector
);
  logic [3:0] shEn;
  logic       edgeWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shEn <= '0;
    else if (cfgWrEn) shEn[cfgSel] <= cfgEnable;
  end

  assign edgeWrite = cfgWrEn && (cfgSel[1] || !cfgMode[1]);

  // R4: only the four legal vectors while requesting
  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector == 8'h03 || irqVector == 8'h0B ||
                irqVector == 8'h13 || irqVector == 8'h1B));

  // R4: vector idles at zero
  assert_vec_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqVector == 8'h00);

  // R8: presented pin must be enabled
  assert_pin_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> shEn[irqVector[4:3]]);

  // R8: no request with every pin disabled
  assert_none_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (shEn == 4'b0000) |-> !irqReq);

  // R7: an edge-mode write leaves that pin unpresented in the next cycle
  assert_cfg_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    edgeWrite |=> !(irqReq && irqVector == (8'h03 + {3'b000, $past(cfgSel), 3'b000})));
endmodule

bind extint_unit extint_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .cfgMode(cfgMode), .cfgEnable(cfgEnable), .irqReq(irqReq), .irqVector(irqVector)
);

// File: tb/extint_unit_bench.sv
`timescale 1ns/1ps
module extint_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pinIn = '0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [1:0] cfgMode = '0;
  logic       cfgEnable = 1'b0;
  logic [1:0] filtSel = '0;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic [7:0] irqVector;
  logic [1:0] tmrEvt;

  int nChecks = 0;
  int nFails  = 0;
  int evt2Cnt = 0;
  int evt3Cnt = 0;
  bit finished = 1'b0;

  extint_unit u_extint_unit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgMode(cfgMode), .cfgEnable(cfgEnable), .filtSel(filtSel), .irqAck(irqAck),
    .irqReq(irqReq), .irqVector(irqVector), .tmrEvt(tmrEvt)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tmrEvt[0]) evt2Cnt <= evt2Cnt + 1;
    if (tmrEvt[1]) evt3Cnt <= evt3Cnt + 1;
  end

  task automatic expectEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expectReq(input string req, input bit expReq, input int pin);
    expectEq(req, int'(irqReq), int'(expReq));
    expectEq(req, int'(irqVector), expReq ? 3 + 8 * pin : 0);
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input int sel, input int mode, input bit en);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 2'(sel); cfgMode = 2'(mode); cfgEnable = en;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  function automatic bit levelExp(input int pin, input int mode, input bit lvl);
    return pin < 2 && ((mode == 2 && lvl) || (mode == 3 && !lvl));
  endfunction

  function automatic bit edgeExp(input int pin, input int mode, input bit rising);
    if (mode == 0) return rising;
    if (mode == 1) return !rising;
    return pin >= 2;
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    int base;
    waitNeg(3);
    // Reset state (R4, R8)
    expectReq("R4 reset", 1'b0, 0);
    expectEq("R10 reset", int'(tmrEvt), 0);
    rstN = 1'b1;
    waitNeg(2);

    // R1 synchroniser latency on pin 0
    writeCfg(0, 0, 1);
    pinIn[0] = 1'b1;
    waitNeg(2);
    expectEq("R1 early", int'(irqReq), 0);
    waitNeg(1);
    expectReq("R1 third edge", 1'b1, 0);
    pulseAck();
    pinIn[0] = 1'b0;
    waitNeg(6);

    // Mode sweep over every pin and mode (R2, R3, R6)
    filtSel = 2'd0;
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        string tag;
        tag = (p < 2) ? "R2" : "R3";
        for (int q = 0; q < 4; q++) if (q != p) writeCfg(q, 0, 0);
        writeCfg(p, m, 1);
        waitNeg(8);
        expectReq(tag, levelExp(p, m, 0), p);
        pinIn[p] = 1'b1;
        waitNeg(8);
        expectReq(tag, edgeExp(p, m, 1) || levelExp(p, m, 1), p);
        pulseAck();
        expectReq("R6 ack", levelExp(p, m, 1), p);
        pinIn[p] = 1'b0;
        waitNeg(8);
        expectReq(tag, edgeExp(p, m, 0) || levelExp(p, m, 0), p);
        pulseAck();
        expectReq("R6 ack", levelExp(p, m, 0), p);
      end
    end

    // R5 priority with all four pending
    for (int q = 0; q < 4; q++) writeCfg(q, 0, 1);
    pinIn = 4'hF;
    waitNeg(10);
    for (int k = 0; k < 4; k++) begin
      expectReq("R5 order", 1'b1, k);
      pulseAck();
    end
    expectReq("R6 all cleared", 1'b0, 0);
    pinIn = 4'h0;
    waitNeg(10);
    expectReq("R3 no fall trigger", 1'b0, 0);

    // R7 configuration write clears pending
    pinIn[0] = 1'b1;
    waitNeg(6);
    expectReq("R7 before", 1'b1, 0);
    writeCfg(0, 0, 1);
    expectReq("R7 after", 1'b0, 0);
    pinIn[0] = 1'b0;
    waitNeg(6);

    // R8 disabled pin
    writeCfg(1, 0, 0);
    pinIn[1] = 1'b1;
    waitNeg(6);
    expectReq("R8 edge disabled", 1'b0, 0);
    writeCfg(1, 2, 0);
    waitNeg(2);
    expectReq("R8 level disabled", 1'b0, 0);
    writeCfg(1, 2, 1);
    waitNeg(1);
    expectReq("R2 level enabled", 1'b1, 1);
    pinIn[1] = 1'b0;
    waitNeg(6);
    writeCfg(1, 0, 0);

    // R10 timer events, independent of enables
    writeCfg(2, 2, 0);
    base = evt2Cnt;
    for (int k = 0; k < 2; k++) begin
      pinIn[2] = 1'b1; waitNeg(5);
      pinIn[2] = 1'b0; waitNeg(5);
    end
    expectEq("R10 both edges pin 2", evt2Cnt - base, 4);
    writeCfg(3, 0, 0);
    base = evt3Cnt;
    for (int k = 0; k < 2; k++) begin
      pinIn[3] = 1'b1; waitNeg(8);
      pinIn[3] = 1'b0; waitNeg(8);
    end
    expectEq("R10 rising pin 3", evt3Cnt - base, 2);
    writeCfg(3, 1, 0);
    base = evt3Cnt;
    pinIn[3] = 1'b1; waitNeg(8);
    pinIn[3] = 1'b0; waitNeg(8);
    expectEq("R10 falling pin 3", evt3Cnt - base, 1);
    expectReq("R8 events without request", 1'b0, 0);

    // R9 filter acceptance over all rates and pulse widths
    for (int q = 0; q < 3; q++) writeCfg(q, 0, 0);
    for (int s = 0; s < 3; s++) begin
      for (int w = 0; w < 2; w++) begin
        int div;
        int width;
        div   = (s == 0) ? 1 : (s == 1) ? 16 : 64;
        width = (w == 1) ? 2 * div : ((s == 0) ? 1 : div);
        filtSel = 2'(s);
        writeCfg(3, 0, 1);
        waitNeg(2 * div + 8);
        pinIn[3] = 1'b1;
        waitNeg(width);
        pinIn[3] = 1'b0;
        waitNeg(2 * div + 10);
        expectReq("R9 filter", width >= 2 * div, 3);
        pulseAck();
      end
    end

    report();
  end
endmodule